// File: doc/BRIEF.md
# Receiver Output Clock and Data Source Selector

This block is the control logic in front of a digital audio receiver's output stage. A serial control bus delivers 16-bit command words. When a word carries this block's bus address, command address and chip address, its upper byte is latched as a set of mode bits. From those bits and the PLL lock status, the block decides two things. The first is whether each of the two output clock systems, R and S, runs from the crystal clock (XIN) or from the recovered PLL clock. The second is what appears on the data output: recovered data, the auxiliary serial input, or silence.

A change of either clock source raises a one-cycle receive-error pulse. The pulse is not raised when the oscillator amplifier is set to run continuously, or when sampling-rate changes are masked from the error flag. The oscillator amplifier can also be set to stop by itself once the PLL locks. In that case, any switch to XIN requested while the PLL is locked waits until the oscillator has been stable for a programmable number of cycles. The clock outputs and the data source then change together on the same edge. All select outputs are registered on the control clock.

Top module: `rx_out_sel`

## Requirements
- R1: A write is accepted only when `wr_en_i` is high and all of the following hold: `bus_addr_i` equals BUS_ADDR (default 0xE8), `wr_data_i[7:4]` equals 5, `wr_data_i[3:2]` equals 0, and `wr_data_i[1:0]` equals CHIP_ID (default 0). Any other write leaves every output unchanged.
- R2: An accepted write loads the mode bits from the upper byte as follows. Bit 8 is split mode. Bit 9 is the common clock select. Bit 10 is the R clock select. Bit 12 is mute-on-unlock. Bit 13 is force-SDIN. Bit 14 is mute. Bits 15 and 11 are ignored.
- R3: While `rst_ni` is low, all mode bits are 0, `r_xin_o`, `s_xin_o`, `sdin_sel_o` and `err_o` are 0, `mute_o` is 1 and `data_o` is all zeros.
- R4: With split mode 0, the R and S systems both follow the common clock select.
- R5: With split mode 1, the R system follows the R clock select and `s_xin_o` is 1.
- R6: A clock select of 1 makes that system use XIN (output 1). A clock select of 0 makes it use XIN exactly while `pll_lock_i` is 1, and the recovered clock (output 0) otherwise.
- R7: Data source priority runs as follows. Mute=1 gives silence. Otherwise, force-SDIN=1 gives `sdin_i`. Otherwise, while unlocked, mute-on-unlock=1 gives silence and 0 gives `sdin_i`. While locked, the output is `rdata_i`.
- R8: Silence drives `data_o` to all zeros with `mute_o`=1. SDIN is flagged by `sdin_sel_o`=1. `data_o` follows the inputs selected by the registered source.
- R9: When `r_xin_o` or `s_xin_o` changes, `err_o` is 1 for exactly that one cycle.
- R10: No error pulse occurs on a change when `amp_cont_i` or `fs_mask_i` was high in the cycle before the change.
- R11: Suppose `auto_stop_i` is 1, `pll_lock_i` is 1, a system's target is XIN while it currently uses the recovered clock, and the oscillator is not yet qualified. Then both clock outputs and the data source hold their values until qualification.
- R12: The oscillator counts as qualified once `osc_ok_i` has been high for SETTLE consecutive cycles, where SETTLE is at least 16. A low cycle restarts the count.
- R13: Outputs are registered. A lock change shows on the next clock edge, and an accepted write shows on the second clock edge after its strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Command word strobe |
| bus_addr_i | input | 8 | Control bus address |
| wr_data_i | input | 16 | Command word |
| pll_lock_i | input | 1 | PLL lock status |
| osc_ok_i | input | 1 | Oscillator running indication |
| auto_stop_i | input | 1 | Amplifier stops automatically on lock |
| amp_cont_i | input | 1 | Amplifier runs continuously |
| fs_mask_i | input | 1 | Rate changes masked from error flag |
| rdata_i | input | DW | Recovered audio data |
| sdin_i | input | DW | Auxiliary serial input data |
| r_xin_o | output | 1 | R system uses XIN (1) or PLL clock (0) |
| s_xin_o | output | 1 | S system uses XIN (1) or PLL clock (0) |
| sdin_sel_o | output | 1 | Data output carries SDIN |
| mute_o | output | 1 | Data output muted |
| data_o | output | DW | Selected output data |
| err_o | output | 1 | Receive-error pulse |

## Verification
The bench builds the block with its default parameters: DW=8, SETTLE=16, CHIP_ID=0 and BUS_ADDR=0xE8. This makes it practical to sweep all 64 combinations of the six mode bits against both lock states, first with error pulses enabled and then with them suppressed. Each resulting clock source, data word and error-pulse count is compared against values computed arithmetically. With SETTLE at 16, the oscillator qualification edge can be probed one cycle on either side of the deferred switch, and a restart of the count can be observed.

// File: rtl/rx_out_sel_pkg.sv
package rx_out_sel_pkg;
  typedef enum logic [1:0] {
    DS_REC  = 2'd0,
    DS_SDIN = 2'd1,
    DS_MUTE = 2'd2
  } dsel_e;

  typedef struct packed {
    logic mute;
    logic sdin_force;
    logic unlock_mute;
    logic r_sel;
    logic com_sel;
    logic split;
  } mode_t;
endpackage

// File: rtl/rx_out_cmd_dec.sv
module rx_out_cmd_dec
  import rx_out_sel_pkg::*;
#(
  parameter logic [7:0] BUS_ADDR = 8'hE8,
  parameter logic [3:0] CMD_ADDR = 4'h5,
  parameter logic [1:0] CHIP_ID  = 2'b00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [15:0] wr_data_i,
  output mode_t       mode_o
);
  mode_t mode_q;
  logic  hit;
  logic  unused_bits;

  assign unused_bits = ^{wr_data_i[15], wr_data_i[11]};

  assign hit = wr_en_i && (bus_addr_i == BUS_ADDR) &&
               (wr_data_i[7:4] == CMD_ADDR) &&
               (wr_data_i[3:2] == 2'b00) &&
               (wr_data_i[1:0] == CHIP_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (hit) begin
      mode_q.mute        <= wr_data_i[14];
      mode_q.sdin_force  <= wr_data_i[13];
      mode_q.unlock_mute <= wr_data_i[12];
      mode_q.r_sel       <= wr_data_i[10];
      mode_q.com_sel     <= wr_data_i[9];
      mode_q.split       <= wr_data_i[8];
    end
  end

  assign mode_o = mode_q;

  assert_foreign_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bus_addr_i != BUS_ADDR) |=> $stable(mode_q));

  assert_bad_chip_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[1:0] != CHIP_ID) |=> $stable(mode_q));
endmodule

// File: rtl/rx_out_osc_settle.sv
module rx_out_osc_settle #(
  parameter int SETTLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_ok_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LIM = CW'(SETTLE);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!osc_ok_i)    cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIM);

  initial begin
    if (SETTLE < 16) $display("rx_out_osc_settle: SETTLE below 16");
  end

  assert_restart_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_ok_i |=> !ready_o);
endmodule

// File: rtl/rx_out_clk_sel.sv
module rx_out_clk_sel
  import rx_out_sel_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  input  logic  pll_lock_i,
  input  logic  osc_ready_i,
  input  logic  auto_stop_i,
  input  logic  amp_cont_i,
  input  logic  fs_mask_i,
  output logic  r_xin_o,
  output logic  s_xin_o,
  output logic  hold_o,
  output logic  err_o
);
  logic r_q, s_q, err_q;
  logic sel_r, tgt_r, tgt_s;
  logic r_nxt, s_nxt, hold;

  assign sel_r = mode_i.split ? mode_i.r_sel : mode_i.com_sel;
  assign tgt_r = sel_r | pll_lock_i;
  assign tgt_s = mode_i.split | mode_i.com_sel | pll_lock_i;

  // switching to XIN from lock waits for a settled oscillator
  assign hold = auto_stop_i && pll_lock_i && !osc_ready_i &&
                ((tgt_r && !r_q) || (tgt_s && !s_q));

  assign r_nxt = hold ? r_q : tgt_r;
  assign s_nxt = hold ? s_q : tgt_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q   <= 1'b0;
      s_q   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      r_q   <= r_nxt;
      s_q   <= s_nxt;
      err_q <= ((r_nxt != r_q) || (s_nxt != s_q)) && !(amp_cont_i || fs_mask_i);
    end
  end

  assign r_xin_o = r_q;
  assign s_xin_o = s_q;
  assign hold_o  = hold;
  assign err_o   = err_q;

  assert_err_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (r_q != $past(r_q) || s_q != $past(s_q)));

  assert_change_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((r_q != $past(r_q) || s_q != $past(s_q)) && !$past(amp_cont_i || fs_mask_i)) |-> err_o);

  assert_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_cont_i || fs_mask_i) |=> !err_o);

  assert_split_s_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.split && !hold) |=> s_q);

  assert_hold_clk_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> ($stable(r_q) && $stable(s_q)));
endmodule

// File: rtl/rx_out_data_sel.sv
module rx_out_data_sel
  import rx_out_sel_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_t         mode_i,
  input  logic          pll_lock_i,
  input  logic          hold_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] sdin_i,
  output logic          sdin_sel_o,
  output logic          mute_o,
  output logic [DW-1:0] data_o
);
  dsel_e sel_q, sel_nxt;

  always_comb begin
    if (mode_i.mute)            sel_nxt = DS_MUTE;
    else if (mode_i.sdin_force) sel_nxt = DS_SDIN;
    else if (!pll_lock_i)       sel_nxt = mode_i.unlock_mute ? DS_MUTE : DS_SDIN;
    else                        sel_nxt = DS_REC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= DS_MUTE;
    else if (!hold_i) sel_q <= sel_nxt;
  end

  always_comb begin
    case (sel_q)
      DS_REC:  data_o = rdata_i;
      DS_SDIN: data_o = sdin_i;
      default: data_o = '0;
    endcase
  end

  assign sdin_sel_o = (sel_q == DS_SDIN);
  assign mute_o     = (sel_q == DS_MUTE);

  assert_mute_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.mute && !hold_i) |=> mute_o);

  assert_force_sdin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i.mute && mode_i.sdin_force && !hold_i) |=> sdin_sel_o);

  assert_hold_data_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(sel_q));

  assert_sel_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sdin_sel_o, mute_o}));
endmodule

// File: rtl/rx_out_sel.sv
module rx_out_sel
  import rx_out_sel_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          SETTLE   = 16,
  parameter logic [7:0]  BUS_ADDR = 8'hE8,
  parameter logic [1:0]  CHIP_ID  = 2'b00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    bus_addr_i,
  input  logic [15:0]   wr_data_i,
  input  logic          pll_lock_i,
  input  logic          osc_ok_i,
  input  logic          auto_stop_i,
  input  logic          amp_cont_i,
  input  logic          fs_mask_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] sdin_i,
  output logic          r_xin_o,
  output logic          s_xin_o,
  output logic          sdin_sel_o,
  output logic          mute_o,
  output logic [DW-1:0] data_o,
  output logic          err_o
);
  mode_t mode;
  logic  osc_ready;
  logic  hold;

  rx_out_cmd_dec #(
    .BUS_ADDR (BUS_ADDR),
    .CMD_ADDR (4'h5),
    .CHIP_ID  (CHIP_ID)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .bus_addr_i (bus_addr_i),
    .wr_data_i  (wr_data_i),
    .mode_o     (mode)
  );

  rx_out_osc_settle #(.SETTLE(SETTLE)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_ok_i (osc_ok_i),
    .ready_o  (osc_ready)
  );

  rx_out_clk_sel u_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .pll_lock_i  (pll_lock_i),
    .osc_ready_i (osc_ready),
    .auto_stop_i (auto_stop_i),
    .amp_cont_i  (amp_cont_i),
    .fs_mask_i   (fs_mask_i),
    .r_xin_o     (r_xin_o),
    .s_xin_o     (s_xin_o),
    .hold_o      (hold),
    .err_o       (err_o)
  );

  rx_out_data_sel #(.DW(DW)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .pll_lock_i (pll_lock_i),
    .hold_i     (hold),
    .rdata_i    (rdata_i),
    .sdin_i     (sdin_i),
    .sdin_sel_o (sdin_sel_o),
    .mute_o     (mute_o),
    .data_o     (data_o)
  );

  assert_lock_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_lock_i && !auto_stop_i && !mode.split) |=> r_xin_o);

  assert_joint_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode.split && !(auto_stop_i && pll_lock_i)) |=> (r_xin_o == s_xin_o));
endmodule

// File: tb/rx_out_sel_test.sv
module rx_out_sel_test;
  localparam int DW = 8;
  localparam logic [7:0] RDV = 8'hA5;
  localparam logic [7:0] SDV = 8'h3C;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [7:0] bus_addr_i = 8'h00;
  logic [15:0] wr_data_i = 16'h0000;
  logic pll_lock_i = 1'b0, osc_ok_i = 1'b0, auto_stop_i = 1'b0;
  logic amp_cont_i = 1'b0, fs_mask_i = 1'b0;
  logic [DW-1:0] rdata_i = RDV, sdin_i = SDV;
  logic r_xin_o, s_xin_o, sdin_sel_o, mute_o, err_o;
  logic [DW-1:0] data_o;

  int checks = 0, failures = 0, err_seen = 0;

  always #2 clk_i = ~clk_i;

  rx_out_sel uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .bus_addr_i(bus_addr_i),
    .wr_data_i(wr_data_i), .pll_lock_i(pll_lock_i), .osc_ok_i(osc_ok_i),
    .auto_stop_i(auto_stop_i), .amp_cont_i(amp_cont_i), .fs_mask_i(fs_mask_i),
    .rdata_i(rdata_i), .sdin_i(sdin_i), .r_xin_o(r_xin_o), .s_xin_o(s_xin_o),
    .sdin_sel_o(sdin_sel_o), .mute_o(mute_o), .data_o(data_o), .err_o(err_o)
  );

  always @(posedge clk_i) begin
    #1;
    if (err_o) err_seen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ba, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; bus_addr_i = ba; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [15:0] word(input logic [5:0] m, input logic junk);
    return {junk, m[5], m[4], m[3], junk, m[2], m[1], m[0], 8'h50};
  endfunction

  function automatic logic exp_r(input logic [5:0] m, input logic lk);
    return (m[0] ? m[2] : m[1]) | lk;
  endfunction

  function automatic logic exp_s(input logic [5:0] m, input logic lk);
    return m[0] | m[1] | lk;
  endfunction

  function automatic logic [7:0] exp_d(input logic [5:0] m, input logic lk);
    if (m[5]) return 8'h00;
    if (m[4]) return SDV;
    if (!lk) return m[3] ? 8'h00 : SDV;
    return RDV;
  endfunction

  initial begin
    #300000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [5:0] cur_m;
    logic cur_lk, pr, ps;
    int base;

    repeat (3) @(negedge clk_i);
    chk("R3 r_xin", r_xin_o, 0);
    chk("R3 s_xin", s_xin_o, 0);
    chk("R3 mute", mute_o, 1);
    chk("R3 data", data_o, 0);
    chk("R3 err", err_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R7 unlocked default sdin", data_o, SDV);
    chk("R8 sdin flag", sdin_sel_o, 1);

    // rejected writes try to set mute
    wr(8'hE9, 16'h7F50); repeat (3) @(negedge clk_i);
    chk("R1 bus addr reject", data_o, SDV);
    wr(8'hE8, 16'h7F60); repeat (3) @(negedge clk_i);
    chk("R1 cmd addr reject", data_o, SDV);
    wr(8'hE8, 16'h7F54); repeat (3) @(negedge clk_i);
    chk("R1 reserved bits reject", data_o, SDV);
    wr(8'hE8, 16'h7F51); repeat (3) @(negedge clk_i);
    chk("R1 chip id reject", data_o, SDV);
    wr(8'hE8, 16'h8850); repeat (3) @(negedge clk_i);
    chk("R2 ignored bits", data_o, SDV);
    chk("R2 ignored bits clk", r_xin_o, 0);

    // latency of an accepted write: mute set
    @(negedge clk_i);
    wr_en_i = 1'b1; bus_addr_i = 8'hE8; wr_data_i = word(6'b100000, 1'b0);
    @(negedge clk_i); wr_en_i = 1'b0;
    chk("R13 one edge after strobe", data_o, SDV);
    @(negedge clk_i);
    chk("R13 two edges after strobe", data_o, 0);
    wr(8'hE8, word(6'b000000, 1'b0)); repeat (3) @(negedge clk_i);

    cur_m = '0; cur_lk = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 64; m++) begin
        amp_cont_i = (p == 1) && m[0];
        fs_mask_i  = (p == 1) && !m[0];
        pr = exp_r(cur_m, cur_lk); ps = exp_s(cur_m, cur_lk);
        base = err_seen;
        wr(8'hE8, word(6'(m), p[0]));
        cur_m = 6'(m);
        repeat (4) @(negedge clk_i);
        chk("R4 R5 R6 r after write", r_xin_o, exp_r(cur_m, cur_lk));
        chk("R5 R6 s after write", s_xin_o, exp_s(cur_m, cur_lk));
        chk("R7 R8 data after write", data_o, exp_d(cur_m, cur_lk));
        chk(p == 0 ? "R9 pulses after write" : "R10 pulses after write", err_seen - base,
            (p == 0 && (pr != exp_r(cur_m, cur_lk) || ps != exp_s(cur_m, cur_lk))) ? 1 : 0);
        pr = exp_r(cur_m, cur_lk); ps = exp_s(cur_m, cur_lk);
        base = err_seen;
        @(negedge clk_i);
        cur_lk = ~cur_lk; pll_lock_i = cur_lk;
        @(negedge clk_i);
        chk("R13 R6 r one edge after lock", r_xin_o, exp_r(cur_m, cur_lk));
        repeat (2) @(negedge clk_i);
        chk("R6 s after lock", s_xin_o, exp_s(cur_m, cur_lk));
        chk("R7 data after lock", data_o, exp_d(cur_m, cur_lk));
        chk(p == 0 ? "R9 pulses after lock" : "R10 pulses after lock", err_seen - base,
            (p == 0 && (pr != exp_r(cur_m, cur_lk) || ps != exp_s(cur_m, cur_lk))) ? 1 : 0);
      end
    end

    // deferred switch with automatic amplifier stop
    amp_cont_i = 1'b0; fs_mask_i = 1'b0;
    rst_ni = 1'b0; pll_lock_i = 1'b0; auto_stop_i = 1'b1; osc_ok_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R11 unlocked start data", data_o, SDV);
    pll_lock_i = 1'b1;
    repeat (6) @(negedge clk_i);
    chk("R11 clock held", r_xin_o, 0);
    chk("R11 data held", data_o, SDV);
    osc_ok_i = 1'b1;
    repeat (10) @(negedge clk_i);
    osc_ok_i = 1'b0;
    @(negedge clk_i);
    osc_ok_i = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R12 count restarted", r_xin_o, 0);
    base = err_seen;
    repeat (6) @(negedge clk_i);
    chk("R12 edge 16 still held", r_xin_o, 0);
    @(negedge clk_i);
    chk("R12 r switched after settle", r_xin_o, 1);
    chk("R11 s switched together", s_xin_o, 1);
    chk("R11 data switched together", data_o, RDV);
    chk("R9 single pulse on deferred switch", err_seen - base, 1);
    repeat (3) @(negedge clk_i);
    chk("R9 pulse not repeated", err_seen - base, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule